// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block is a compact serial transmitter and receiver with optional parity. It centres on four status flags: transmit buffer empty, receive buffer full, parity fault and transmission finished. Software reaches the block through a small register bus with four locations: control, transmit data, status and receive data. A separate DMA strobe can load the transmit data register directly. Bit timing comes from an external baud tick input, and each bit lasts one tick period. A standby input returns the flags and both shifters to their reset condition. The control register and the data registers keep their contents through standby.

Software can clear a clearable flag only with a handshake. It must first read the status register while the flag is 1, and then write 0 to that flag's bit. A byte that arrives with bad parity is still stored, but it raises the parity fault instead of the full flag. Reception then stops until software clears the fault. In synchronous mode the fault also stops transmission.

None of the interfaces uses back-pressure. Bus accesses and DMA strobes complete in the cycle they are presented, and the serial pins are plain levels sampled or driven on baud ticks. The register map is as follows.

- Address 0 is control: bit0 receive enable, bit1 transmit enable, bit2 parity enable, bit3 odd parity, bit4 synchronous mode.
- Address 1 is transmit data, readable and writable.
- Address 2 is status: bit0 transmit empty, bit1 receive full, bit2 parity fault, bit3 transmit finished.
- Address 3 is receive data, read-only.

Top module: `serial_status_unit`

## Requirements
- R1: After reset, and for any cycle in which standby is high, the status reads 0x09: transmit empty and transmit finished are 1, receive full and parity fault are 0.
- R2: In asynchronous mode each character goes out as follows: a 0 start bit, the 8 data bits with the least significant first, a parity bit when parity is enabled, and a 1 stop bit, one bit per tick. Even parity sends the XOR of the data bits and odd parity sends its inverse. The line idles at 1.
- R3: While transmit is enabled, the shifter is idle and transmit empty is 0, the shifter loads the transmit data register, and transmit empty returns to 1 in the same cycle.
- R4: Transmit finished becomes 1 when the last bit of a character ends while transmit empty is 1. If a new byte is pending at that moment, it stays 0.
- R5: Transmit finished is held at 1 while transmit enable is 0, and bus writes to its status bit have no effect.
- R6: A status write of 0 clears a clearable flag only if a status read has returned that flag as 1 since the last status write. Writing 1 to a flag bit changes nothing, and every status write disarms all flags.
- R7: A valid clear of transmit empty also clears transmit finished. A DMA strobe writes the transmit data register and clears both flags.
- R8: In asynchronous mode a frame is received as a 0 start bit, 8 data bits with the least significant first, a parity bit when enabled, and a stop bit, all sampled on ticks. If the parity matches, the byte goes to the receive data register and receive full is set.
- R9: On a parity mismatch (even parity: the count of ones over the data and parity bit is odd; odd parity: that count is even), the byte is still written to the receive data register, receive full is left unchanged and parity fault is set.
- R10: While parity fault is 1, no new frame is accepted. Turning off receive enable leaves parity fault unchanged.
- R11: In synchronous mode a character is only the 8 data bits, least significant first, one per tick. No byte is loaded for transmission while parity fault is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Forces flags to reset values and idles both shifters |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| bus_sel | input | 1 | Register bus select |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read, 0 otherwise |
| dma_wr | input | 1 | DMA strobe loading the transmit data register |
| dma_data | input | DATA_W | DMA write data |
| rx_line | input | 1 | Serial receive line |
| tx_line | output | 1 | Serial transmit line |

## Verification
Arming state that is set wrongly or not cleared shows up on the first status write after a read. A flag then clears when it should not, or survives the write, and the next status read reveals this one cycle later. Errors in the load or finish logic of the transmit shifter show up within one tick period. Either the line shows a bad bit, or the finished flag changes at the wrong end of a frame, or a pending byte is never sent. Receive-side errors show up in the status and receive data registers two cycles after the stop-bit tick.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_TXD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 2'd3;

  localparam int unsigned C_RXEN = 0;
  localparam int unsigned C_TXEN = 1;
  localparam int unsigned C_PEN  = 2;
  localparam int unsigned C_PODD = 3;
  localparam int unsigned C_SYNC = 4;

  typedef struct packed {
    logic tx_done;
    logic par_fault;
    logic rx_full;
    logic tx_empty;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
  localparam int unsigned ARM_W  = STAT_W - 1;
endpackage

// File: rtl/sfc_tx.sv
`timescale 1ns/1ps
module sfc_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              tick,
  input  logic              go,
  input  logic              sync_mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] data,
  output logic              load,
  output logic              last,
  output logic              line
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   rem_q, len_d;
  logic               par_bit;

  always_comb begin
    par_bit = (^data) ^ par_odd;
    frame_d = '1;
    len_d   = CNT_W'(DATA_W + 2);
    if (sync_mode) begin
      frame_d[DATA_W-1:0] = data;
      len_d = CNT_W'(DATA_W);
    end else if (par_en) begin
      frame_d = {1'b1, par_bit, data, 1'b0};
      len_d = CNT_W'(DATA_W + 3);
    end else begin
      frame_d = {2'b11, data, 1'b0};
    end
  end

  assign load = !busy_q && go && !abort;
  assign last = busy_q && tick && (rem_q == CNT_W'(1));
  assign line = busy_q ? frame_q[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      rem_q   <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      frame_q <= frame_d;
      rem_q   <= len_d;
    end else if (busy_q && tick) begin
      if (rem_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
        rem_q   <= rem_q - CNT_W'(1);
      end
    end
  end

  // R2: a frame only ends on a tick boundary or by abort
  assert_tx_ends_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(tick) || $past(abort)));
  // R3: a load is always followed by an active shifter
  assert_tx_load_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q || $past(abort)));
endmodule

// File: rtl/sfc_rx.sv
`timescale 1ns/1ps
module sfc_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              hold,
  input  logic              tick,
  input  logic              line,
  input  logic              sync_mode,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic              bad,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 3);

  logic [CNT_W-1:0]  cnt_q, stop_pos;
  logic [DATA_W-1:0] sh_q, sh_next;
  logic              pbit_q;

  assign stop_pos = par_en ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
  assign sh_next  = {line, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      done    <= 1'b0;
      bad     <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (sync_mode) begin
          if (cnt_q != '0 || !hold) begin
            sh_q <= sh_next;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cnt_q   <= '0;
              done    <= 1'b1;
              bad     <= 1'b0;
              rx_byte <= sh_next;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end else if (cnt_q == '0) begin
          if (!hold && !line) cnt_q <= CNT_W'(1);
        end else if (cnt_q <= CNT_W'(DATA_W)) begin
          sh_q  <= sh_next;
          cnt_q <= cnt_q + CNT_W'(1);
        end else if (cnt_q == stop_pos) begin
          cnt_q   <= '0;
          done    <= 1'b1;
          rx_byte <= sh_q;
          bad     <= par_en && ((^{sh_q, pbit_q}) != par_odd);
        end else begin
          pbit_q <= line;
          cnt_q  <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // R10: with a parity fault pending, an idle receiver stays idle
  assert_rx_held_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && cnt_q == '0) |=> (cnt_q == '0));
  // R8: completion is a single-cycle pulse
  assert_rx_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sfc_status.sv
`timescale 1ns/1ps
module sfc_status
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             tx_en,
  input  logic             st_rd,
  input  logic             st_wr,
  input  logic [ARM_W-1:0] wr_bits,
  input  logic             dma_wr,
  input  logic             tx_load,
  input  logic             tx_last,
  input  logic             rx_done,
  input  logic             rx_bad,
  output stat_t            stat
);
  logic [ARM_W-1:0] arm_q, live, clr;
  stat_t            st_q;

  assign live = {st_q.par_fault, st_q.rx_full, st_q.tx_empty};
  assign clr  = {ARM_W{st_wr}} & arm_q & ~wr_bits;
  assign stat = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n || standby) begin
      arm_q          <= '0;
      st_q.tx_empty  <= 1'b1;
      st_q.rx_full   <= 1'b0;
      st_q.par_fault <= 1'b0;
      st_q.tx_done   <= 1'b1;
    end else begin
      if (st_wr)      arm_q <= '0;
      else if (st_rd) arm_q <= arm_q | live;

      if (dma_wr)       st_q.tx_empty <= 1'b0;
      else if (tx_load) st_q.tx_empty <= 1'b1;
      else if (clr[0])  st_q.tx_empty <= 1'b0;

      if (!tx_en)                         st_q.tx_done <= 1'b1;
      else if (dma_wr || clr[0])          st_q.tx_done <= 1'b0;
      else if (tx_last && st_q.tx_empty)  st_q.tx_done <= 1'b1;

      if (rx_done && !rx_bad) st_q.rx_full <= 1'b1;
      else if (clr[1])        st_q.rx_full <= 1'b0;

      if (rx_done && rx_bad) st_q.par_fault <= 1'b1;
      else if (clr[2])       st_q.par_fault <= 1'b0;
    end
  end

  // R6: receive full only drops through an armed write or standby
  assert_clear_needs_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q.rx_full) |-> ($past(standby) || $past(st_wr && arm_q[1])));
  // R9: a bad frame raises the fault and leaves receive full alone
  assert_bad_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_bad && !standby && !st_wr) |=>
      (st_q.par_fault && st_q.rx_full == $past(st_q.rx_full)));
  // R4: finished only rises with nothing pending or transmit off
  assert_done_needs_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q.tx_done) |-> $past(!tx_en || standby || st_q.tx_empty));
endmodule

// File: rtl/serial_status_unit.sv
`timescale 1ns/1ps
module serial_status_unit
  import sfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              baud_tick,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_data,
  input  logic              rx_line,
  output logic              tx_line
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] tdr_q, rdr_q, rx_byte;
  logic              st_rd, st_wr, tx_go, tx_load, tx_last, rx_done, rx_bad;
  stat_t             stat;

  assign st_rd = bus_sel && bus_rd && (bus_addr == A_STAT);
  assign st_wr = bus_sel && bus_wr && (bus_addr == A_STAT);
  assign tx_go = ctrl_q[C_TXEN] && !stat.tx_empty &&
                 !(ctrl_q[C_SYNC] && stat.par_fault);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tdr_q  <= '0;
      rdr_q  <= '0;
    end else begin
      if (bus_sel && bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (dma_wr)                                  tdr_q  <= dma_data;
      else if (bus_sel && bus_wr && bus_addr == A_TXD) tdr_q <= bus_wdata;
      if (rx_done) rdr_q <= rx_byte;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
        A_TXD:   bus_rdata = tdr_q;
        A_STAT:  bus_rdata[STAT_W-1:0] = stat;
        default: bus_rdata = rdr_q;
      endcase
    end
  end

  sfc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .abort(standby || !ctrl_q[C_TXEN]),
    .tick(baud_tick), .go(tx_go), .sync_mode(ctrl_q[C_SYNC]),
    .par_en(ctrl_q[C_PEN]), .par_odd(ctrl_q[C_PODD]), .data(tdr_q),
    .load(tx_load), .last(tx_last), .line(tx_line)
  );

  sfc_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .abort(standby || !ctrl_q[C_RXEN]),
    .hold(stat.par_fault), .tick(baud_tick), .line(rx_line),
    .sync_mode(ctrl_q[C_SYNC]), .par_en(ctrl_q[C_PEN]), .par_odd(ctrl_q[C_PODD]),
    .done(rx_done), .bad(rx_bad), .rx_byte(rx_byte)
  );

  sfc_status u_stat (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tx_en(ctrl_q[C_TXEN]),
    .st_rd(st_rd), .st_wr(st_wr), .wr_bits(bus_wdata[ARM_W-1:0]),
    .dma_wr(dma_wr), .tx_load(tx_load), .tx_last(tx_last),
    .rx_done(rx_done), .rx_bad(rx_bad), .stat(stat)
  );

  // R1: standby leaves the flags at their reset pattern
  assert_standby_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (stat.tx_empty && stat.tx_done && !stat.rx_full && !stat.par_fault));
  // R11: synchronous mode never starts a byte while a fault is pending
  assert_sync_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_SYNC] && stat.par_fault) |-> !tx_load);
endmodule

// File: tb/sim_serial_status_unit.sv
`timescale 1ns/1ps
module sim_serial_status_unit;
  localparam int DW = 8;
  localparam int TICK_DIV = 6;

  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0, baud_tick = 1'b0;
  logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, dma_wr = 1'b0, rx_line = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic [DW-1:0] bus_wdata = '0, dma_data = '0, bus_rdata;
  logic tx_line;

  always #2 clk = ~clk;

  serial_status_unit #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .standby(standby), .baud_tick(baud_tick),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_wr(dma_wr),
    .dma_data(dma_data), .rx_line(rx_line), .tx_line(tx_line)
  );

  int n_cmp = 0, n_bad = 0, frames_seen = 0, tick_cnt = 0;
  logic [7:0] exp_q[$];
  bit mon_on = 0, cur_pen = 0, cur_podd = 0;

  always @(negedge clk) begin
    if (tick_cnt == TICK_DIV - 1) begin tick_cnt <= 0; baud_tick <= 1'b1; end
    else begin tick_cnt <= tick_cnt + 1; baud_tick <= 1'b0; end
  end

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic next_tick;
    do begin @(negedge clk); #1; end while (!baud_tick);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1; bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1; bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); #1; bus_sel = 1; bus_rd = 1; bus_addr = a; #1; d = bus_rdata;
    @(negedge clk); #1; bus_sel = 0; bus_rd = 0;
  endtask

  // combinational look at status with no clock edge in between (no arming)
  task automatic peek(output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = 2'd2; #1; d = bus_rdata;
    bus_sel = 0; bus_rd = 0;
  endtask

  // driver: load TDR, record expectation, then clear transmit empty by handshake
  task automatic send_tx(input logic [7:0] b);
    logic [7:0] r;
    bus_write(2'd1, b);
    exp_q.push_back(b);
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h0E);
  endtask

  task automatic send_rx(input logic [7:0] b, input bit with_par, input bit pbit);
    rx_line = 1'b0; next_tick; @(negedge clk); #1;
    for (int k = 0; k < 8; k++) begin rx_line = b[k]; next_tick; @(negedge clk); #1; end
    if (with_par) begin rx_line = pbit; next_tick; @(negedge clk); #1; end
    rx_line = 1'b1; next_tick; @(negedge clk); #1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic wait_frames(input int n);
    int guard = 0;
    while (frames_seen < n && guard < 3000) begin @(negedge clk); #2; guard++; end
    if (frames_seen < n) check("R2", "frame never seen", 8'(frames_seen), 8'(n));
  endtask

  // monitor: decodes asynchronous frames and compares against the queue
  initial begin : monitor
    forever begin
      logic [7:0] got, want;
      logic pb, sb;
      @(negedge clk); #1;
      if (mon_on && baud_tick && tx_line == 1'b0) begin
        for (int k = 0; k < 8; k++) begin next_tick; got[k] = tx_line; end
        pb = 1'b0;
        if (cur_pen) begin next_tick; pb = tx_line; end
        next_tick; sb = tx_line;
        if (exp_q.size() == 0) check("R2", "unexpected frame", got, 8'hxx);
        else begin
          want = exp_q.pop_front();
          check("R2", "tx data", got, want);
          if (cur_pen) check("R2", "tx parity bit", 8'(pb), 8'((^want) ^ cur_podd));
          check("R2", "tx stop bit", 8'(sb), 8'h01);
        end
        frames_seen++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] r, got;
    int guard;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_read(2'd2, r); check("R1", "status after reset", r, 8'h09);

    // async, even parity
    cur_pen = 1; cur_podd = 0; mon_on = 1;
    bus_write(2'd0, 8'h07);
    send_tx(8'hA5);
    peek(r); check("R7", "clear of empty also clears finished", r, 8'h00);
    @(negedge clk); #1;
    peek(r); check("R3", "shifter loaded, empty back to 1", r, 8'h01);
    wait_frames(1);
    repeat (2) @(negedge clk);
    bus_read(2'd2, r); check("R4", "finished after last bit", r, 8'h09);

    // unarmed write must not clear
    bus_write(2'd1, 8'h3C);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, r); check("R6", "unarmed write of 0 ignored", r, 8'h09);
    send_tx(8'h3C);
    repeat (3) @(negedge clk);
    send_tx(8'h81);
    wait_frames(2);
    @(negedge clk); #1;
    peek(r); check("R4", "finished held low with byte pending", r, 8'h00);
    wait_frames(3);

    // odd parity
    bus_write(2'd0, 8'h0F); cur_podd = 1;
    send_tx(8'h07);
    wait_frames(4);
    // no parity
    bus_write(2'd0, 8'h03); cur_pen = 0; cur_podd = 0;
    send_tx(8'hF0);
    wait_frames(5);

    // DMA path
    bus_write(2'd0, 8'h07); cur_pen = 1;
    @(negedge clk); #1; dma_wr = 1; dma_data = 8'h5A; exp_q.push_back(8'h5A);
    @(negedge clk); #1; dma_wr = 0;
    peek(r); check("R7", "DMA clears empty and finished", r, 8'h00);
    wait_frames(6);
    repeat (2) @(negedge clk);

    // finished bit is read-only
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h07);
    bus_read(2'd2, r); check("R5", "write to finished ignored", r, 8'h09);

    // transmit disabled: finished forced
    bus_write(2'd0, 8'h05);
    bus_write(2'd1, 8'hC3);
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h0E);
    repeat (3) @(negedge clk); #1;
    peek(r); check("R5", "finished held while transmit off", r, 8'h08);

    // receive, even parity
    send_rx(8'h96, 1, 1'b0);
    bus_read(2'd2, r); check("R8", "receive full set", r, 8'h0A);
    bus_read(2'd3, r); check("R8", "received byte", r, 8'h96);
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h0D);
    bus_read(2'd2, r); check("R6", "armed clear of receive full", r, 8'h08);

    send_rx(8'h33, 1, 1'b1);
    bus_read(2'd2, r); check("R9", "parity fault, no full", r, 8'h0C);
    bus_read(2'd3, r); check("R9", "bad byte still stored", r, 8'h33);

    send_rx(8'h44, 1, 1'b0);
    bus_read(2'd2, r); check("R10", "no reception while fault", r, 8'h0C);
    bus_read(2'd3, r); check("R10", "data register unchanged", r, 8'h33);
    bus_write(2'd0, 8'h04);
    bus_read(2'd2, r); check("R10", "receive off keeps fault", r, 8'h0C);

    // synchronous transmit blocked by fault
    mon_on = 0;
    bus_write(2'd0, 8'h12);
    repeat (40) @(negedge clk); #1;
    peek(r); check("R11", "sync load blocked by fault", r, 8'h0C);
    check("R11", "line idle while blocked", 8'(tx_line), 8'h01);
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h0B);
    guard = 0;
    peek(r);
    while (!r[0] && guard < 50) begin @(negedge clk); #1; peek(r); guard++; end
    check("R11", "sync load after fault cleared", r & 8'h05, 8'h01);
    for (int k = 0; k < 8; k++) begin
      while (!baud_tick) begin @(negedge clk); #1; end
      got[k] = tx_line;
      @(negedge clk); #1;
    end
    check("R11", "sync data bits", got, 8'hC3);
    repeat (12) @(negedge clk);

    // standby
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h11);
    bus_read(2'd2, r);
    bus_write(2'd2, 8'h0E);
    bus_read(2'd2, r); check("R1", "empty cleared before standby", r, 8'h08);
    @(negedge clk); #1; standby = 1;
    @(negedge clk); #1; standby = 0;
    bus_read(2'd2, r); check("R1", "status after standby", r, 8'h09);

    check("R2", "scoreboard drained", 8'(exp_q.size()), 8'h00);
    summary();
    $finish;
  end
endmodule